// File: doc/BRIEF.md
# Two-Register 8-bit ALU

This block is the arithmetic and logic unit of a small processor that has only two working registers, A and B. Both registers are always wired in as the main operands. A third operand input carries whichever register the instruction names as the source for increment and decrement. A five-bit operation code picks one function, and the 8-bit result goes back to the destination register that the decoder chose. Register storage, memory access and instruction decode are outside this block.

Alongside the result, the unit always drives three compare flags (equal, greater-than and less-than) that relate A to B as unsigned numbers. A branch unit reads these flags directly, whatever operation is selected. The block is purely combinational: a new operand or operation code shows on the outputs in the same cycle. There is no clock or reset input.

Top module: `alu2r_core`

## Requirements
- R1: Code 0 (add) gives (A + B) mod 256 and code 1 (subtract) gives (A - B) mod 256. A is always the first operand and B the second.
- R2: Code 2 (multiply) gives the low 8 bits of the unsigned product A * B.
- R3: Code 3 gives A shifted left by one bit with a zero entering bit 0. Code 4 gives A shifted right by one bit with a zero entering bit 7.
- R4: Code 5 gives the source operand plus one and code 6 gives the source operand minus one, both mod 256, so 0xFF+1 = 0x00 and 0x00-1 = 0xFF. Register A has no effect on these two codes.
- R5: Codes 7, 8 and 9 give 0x01 when A == B, A > B or A < B respectively (unsigned), and 0x00 otherwise.
- R6: Code 10 gives A AND B, code 11 gives A OR B, code 12 gives A XOR B, code 13 gives the bitwise inverse of A, and code 14 gives A unchanged.
- R7: Every code from 15 to 31 gives a result of 0x00.
- R8: For any operation code, eq_o, gt_o and lt_o show the unsigned relation of A to B, and exactly one of them is high.
- R9: The outputs follow a change of any input in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation select code |
| a_i | input | 8 | Register A value |
| b_i | input | 8 | Register B value |
| src_i | input | 8 | Source register value for increment and decrement |
| result_o | output | 8 | Value to be written to the destination register |
| eq_o | output | 1 | A equals B |
| gt_o | output | 1 | A greater than B, unsigned |
| lt_o | output | 1 | A less than B, unsigned |

## Verification
Result selection and flag generation both run in every cycle. When the selected operation is itself a set-on-compare, both derive from the same A and B at once. Each table vector therefore checks the result and all three flags in the same sample. The set-on-compare vectors with equal, greater and smaller operands confirm that the 0/1 result agrees with the flag that names the same relation. A sweep of A against a fixed B with the greater-than code selected checks the two paths together at every operand value.

// File: rtl/alu2r_pkg.sv
package alu2r_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_SUB  = 5'd1,
    OP_MUL  = 5'd2,
    OP_SHL  = 5'd3,
    OP_SHR  = 5'd4,
    OP_INC  = 5'd5,
    OP_DEC  = 5'd6,
    OP_SEQ  = 5'd7,
    OP_SGT  = 5'd8,
    OP_SLT  = 5'd9,
    OP_AND  = 5'd10,
    OP_OR   = 5'd11,
    OP_XOR  = 5'd12,
    OP_NOT  = 5'd13,
    OP_PASS = 5'd14
  } alu_op_e;
endpackage

// File: rtl/alu2r_arith.sv
module alu2r_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] s,
  output logic [W-1:0] sum,
  output logic [W-1:0] diff,
  output logic [W-1:0] prod,
  output logic [W-1:0] incr,
  output logic [W-1:0] decr
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  function automatic logic [W-1:0] f_add(input logic [W-1:0] x, input logic [W-1:0] y);
    return x + y;
  endfunction

  function automatic logic [W-1:0] f_sub(input logic [W-1:0] x, input logic [W-1:0] y);
    return x - y;
  endfunction

  // Both operands are W wide, so the product is truncated to its low half.
  function automatic logic [W-1:0] f_mul_lo(input logic [W-1:0] x, input logic [W-1:0] y);
    return x * y;
  endfunction

  always_comb begin
    sum  = f_add(a, b);
    diff = f_sub(a, b);
    prod = f_mul_lo(a, b);
    incr = f_add(s, ONE);
    decr = f_sub(s, ONE);
  end

  always_comb begin
    a_r4_inc_wrap: assert (!(s == {W{1'b1}}) || incr == '0)
      else $error("increment of all-ones did not wrap");
    a_r4_dec_wrap: assert (!(s == '0) || decr == {W{1'b1}})
      else $error("decrement of zero did not wrap");
  end
endmodule

// File: rtl/alu2r_logic.sv
module alu2r_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] and_v,
  output logic [W-1:0] or_v,
  output logic [W-1:0] xor_v,
  output logic [W-1:0] not_v,
  output logic [W-1:0] shl_v,
  output logic [W-1:0] shr_v
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign and_v[i] = a[i] & b[i];
    assign or_v[i]  = a[i] | b[i];
    assign xor_v[i] = a[i] ^ b[i];
    assign not_v[i] = ~a[i];
    if (i == 0) begin : g_lsb
      assign shl_v[i] = 1'b0;
    end else begin : g_shl
      assign shl_v[i] = a[i-1];
    end
    if (i == W - 1) begin : g_msb
      assign shr_v[i] = 1'b0;
    end else begin : g_shr
      assign shr_v[i] = a[i+1];
    end
  end

  always_comb begin
    a_r3_shr_fill: assert (shr_v[W-1] == 1'b0 && shl_v[0] == 1'b0)
      else $error("shift fill bit not zero");
  end
endmodule

// File: rtl/alu2r_cmp.sv
module alu2r_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         eq,
  output logic         gt,
  output logic         lt
);
  // Unsigned compare from the borrow of a widened subtraction.
  function automatic logic [W:0] f_borrow_diff(input logic [W-1:0] x, input logic [W-1:0] y);
    return {1'b0, x} - {1'b0, y};
  endfunction

  logic [W:0] wide_diff;

  always_comb begin
    wide_diff = f_borrow_diff(a, b);
    lt = wide_diff[W];
    eq = (wide_diff[W-1:0] == '0);
    gt = !wide_diff[W] && !eq;
  end

  always_comb begin
    a_r8_eq_operands: assert (eq == (a == b))
      else $error("equal flag disagrees with operands");
    a_r8_lt_operands: assert (lt == (a < b))
      else $error("less flag disagrees with operands");
  end
endmodule

// File: rtl/alu2r_core.sv
module alu2r_core
  import alu2r_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [W-1:0]    src_i,
  output logic [W-1:0]    result_o,
  output logic            eq_o,
  output logic            gt_o,
  output logic            lt_o
);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] sum, diff, prod, incr, decr;
  logic [W-1:0] and_v, or_v, xor_v, not_v, shl_v, shr_v;
  logic         flag_eq, flag_gt, flag_lt;
  logic         op_is_set;
  logic         op_unused;

  function automatic logic [W-1:0] f_bool(input logic f);
    return {{(W-1){1'b0}}, f};
  endfunction

  alu2r_arith #(.W(W)) u_arith (
    .a(a_i), .b(b_i), .s(src_i),
    .sum(sum), .diff(diff), .prod(prod), .incr(incr), .decr(decr)
  );

  alu2r_logic #(.W(W)) u_logic (
    .a(a_i), .b(b_i),
    .and_v(and_v), .or_v(or_v), .xor_v(xor_v),
    .not_v(not_v), .shl_v(shl_v), .shr_v(shr_v)
  );

  alu2r_cmp #(.W(W)) u_cmp (
    .a(a_i), .b(b_i), .eq(flag_eq), .gt(flag_gt), .lt(flag_lt)
  );

  always_comb begin
    op_is_set = 1'b0;
    op_unused = 1'b0;
    unique case (op_i)
      OP_ADD:  result_o = sum;
      OP_SUB:  result_o = diff;
      OP_MUL:  result_o = prod;
      OP_SHL:  result_o = shl_v;
      OP_SHR:  result_o = shr_v;
      OP_INC:  result_o = incr;
      OP_DEC:  result_o = decr;
      OP_SEQ:  begin result_o = f_bool(flag_eq); op_is_set = 1'b1; end
      OP_SGT:  begin result_o = f_bool(flag_gt); op_is_set = 1'b1; end
      OP_SLT:  begin result_o = f_bool(flag_lt); op_is_set = 1'b1; end
      OP_AND:  result_o = and_v;
      OP_OR:   result_o = or_v;
      OP_XOR:  result_o = xor_v;
      OP_NOT:  result_o = not_v;
      OP_PASS: result_o = a_i;
      default: begin result_o = ZERO; op_unused = 1'b1; end
    endcase
  end

  assign eq_o = flag_eq;
  assign gt_o = flag_gt;
  assign lt_o = flag_lt;

  always_comb begin
    a_r8_flags_onehot: assert ($countones({flag_eq, flag_gt, flag_lt}) == 1)
      else $error("compare flags not one-hot");
    a_r5_set_is_bool: assert (!op_is_set || result_o[W-1:1] == '0)
      else $error("set-on-compare result wider than one bit");
    a_r5_seq_matches_flag: assert (!(op_i == OP_SEQ) || result_o[0] == eq_o)
      else $error("set-equal result disagrees with flag");
    a_r7_unused_zero: assert (!op_unused || result_o == ZERO)
      else $error("unused code gave nonzero result");
  end
endmodule

// File: tb/sim_alu2r_core.sv
module sim_alu2r_core;
  logic       clk = 1'b0;
  logic [4:0] op  = 5'd0;
  logic [7:0] a   = 8'h00;
  logic [7:0] b   = 8'h00;
  logic [7:0] s   = 8'h00;
  logic [7:0] res;
  logic       eq, gt, lt;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  alu2r_core u0 (
    .op_i(op), .a_i(a), .b_i(b), .src_i(s),
    .result_o(res), .eq_o(eq), .gt_o(gt), .lt_o(lt)
  );

  // {op, a, b, src, expected result}
  localparam int NV = 31;
  localparam logic [36:0] VECS [NV] = '{
    {5'd0,  8'h0A, 8'h14, 8'h00, 8'h1E},
    {5'd0,  8'hFF, 8'h01, 8'h00, 8'h00},
    {5'd1,  8'h05, 8'h03, 8'h00, 8'h02},
    {5'd1,  8'h00, 8'h01, 8'h00, 8'hFF},
    {5'd1,  8'h03, 8'h05, 8'h00, 8'hFE},
    {5'd2,  8'h10, 8'h10, 8'h00, 8'h00},
    {5'd2,  8'h07, 8'h06, 8'h00, 8'h2A},
    {5'd2,  8'hFF, 8'hFF, 8'h00, 8'h01},
    {5'd3,  8'h81, 8'h00, 8'h00, 8'h02},
    {5'd3,  8'h40, 8'hFF, 8'h00, 8'h80},
    {5'd4,  8'h81, 8'h00, 8'h00, 8'h40},
    {5'd4,  8'h01, 8'h00, 8'h00, 8'h00},
    {5'd5,  8'h12, 8'h34, 8'hFF, 8'h00},
    {5'd5,  8'h12, 8'h34, 8'h7F, 8'h80},
    {5'd6,  8'h12, 8'h34, 8'h00, 8'hFF},
    {5'd6,  8'h12, 8'h34, 8'h80, 8'h7F},
    {5'd7,  8'h5A, 8'h5A, 8'h00, 8'h01},
    {5'd7,  8'h5A, 8'h5B, 8'h00, 8'h00},
    {5'd8,  8'h80, 8'h7F, 8'h00, 8'h01},
    {5'd8,  8'h00, 8'hFF, 8'h00, 8'h00},
    {5'd9,  8'h00, 8'hFF, 8'h00, 8'h01},
    {5'd9,  8'hFF, 8'hFF, 8'h00, 8'h00},
    {5'd10, 8'hF0, 8'h3C, 8'h00, 8'h30},
    {5'd11, 8'hF0, 8'h0F, 8'h00, 8'hFF},
    {5'd12, 8'hAA, 8'hFF, 8'h00, 8'h55},
    {5'd13, 8'h00, 8'h77, 8'h00, 8'hFF},
    {5'd13, 8'hA5, 8'h00, 8'h00, 8'h5A},
    {5'd14, 8'hC3, 8'h11, 8'h00, 8'hC3},
    {5'd15, 8'hFF, 8'hFF, 8'hFF, 8'h00},
    {5'd31, 8'hAA, 8'h55, 8'h01, 8'h00},
    {5'd20, 8'h01, 8'h02, 8'h03, 8'h00}
  };

  function automatic string tag_of(input logic [4:0] code);
    if (code <= 5'd1)  return "R1";
    if (code == 5'd2)  return "R2";
    if (code <= 5'd4)  return "R3";
    if (code <= 5'd6)  return "R4";
    if (code <= 5'd9)  return "R5";
    if (code <= 5'd14) return "R6";
    return "R7";
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h (op=%0d a=%02h b=%02h src=%02h)",
               req, act, exp, op, a, b, s);
    end
  endtask

  // R8: flags predicted from the signed difference of the operands.
  task automatic chk_flags();
    int d;
    logic [7:0] want, got;
    d = int'(a) - int'(b);
    want = {5'd0, d == 0, d > 0, d < 0};
    got  = {5'd0, eq, gt, lt};
    chk("R8", got, want);
  endtask

  task automatic apply(input logic [4:0] o, input logic [7:0] va, input logic [7:0] vb,
                       input logic [7:0] vs);
    @(posedge clk);
    op = o; a = va; b = vb; s = vs;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    // Initial state with all inputs zero: add of zeros, equal flag.
    @(negedge clk);
    chk("R1", res, 8'h00);
    chk_flags();

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i][36:32], VECS[i][31:24], VECS[i][23:16], VECS[i][15:8]);
      chk(tag_of(VECS[i][36:32]), res, VECS[i][7:0]);
      chk_flags();
    end

    // R5 with R8: greater-than code swept across every A against a mid B.
    for (int i = 0; i < 256; i++) begin
      apply(5'd8, 8'(i), 8'h80, 8'h00);
      chk("R5", res, (i > 128) ? 8'h01 : 8'h00);
      chk_flags();
    end

    // R4: increment and decrement over every source, A set to differ.
    for (int i = 0; i < 256; i++) begin
      apply(5'd5, 8'(i) ^ 8'h5A, 8'h00, 8'(i));
      chk("R4", res, 8'((i + 1) % 256));
      apply(5'd6, 8'(255 - i), 8'h01, 8'(i));
      chk("R4", res, 8'((i + 255) % 256));
    end

    // R7: every unused code, with all-ones operands.
    for (int c = 15; c < 32; c++) begin
      apply(5'(c), 8'hFF, 8'hFF, 8'hFF);
      chk("R7", res, 8'h00);
    end

    // R9: inputs changed between edges; outputs follow with no clock.
    @(negedge clk);
    op = 5'd0; a = 8'h21; b = 8'h02;
    #1;
    chk("R9", res, 8'h23);
    a = 8'h01;
    #1;
    chk("R9", res, 8'h03);
    chk_flags();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule